// File: doc/BRIEF.md
# Serial Flash Identification and Status Responder

This block is the slave side of a serial NOR flash for the commands a host uses to identify the part and to poll its status. It is clocked directly by the serial clock in mode 0. Opcode and parameter bytes come in on the data input, sampled on rising clock edges. Reply bytes go out most significant bit first, and each new reply bit is presented on the falling edge. A separate output enable tells the pad when to drive the reply line.

Three identification queries are answered. Each has its own layout of dummy bytes and its own reply order. One of them takes a selector byte that decides which of the two IDs comes first. A status register query returns a byte built from configured protect settings and a write-enable latch. The reply repeats for as long as the host keeps clocking. Two single-byte commands set and clear the latch. Chip select high aborts any transaction at once. The latch is kept across transactions and cleared only by the power-on reset.

Top module: `spi_id_responder`

## Requirements
- R1: While csN is high, misoEn is 0 and misoData is 0. Raising csN in the middle of a reply drops misoEn before the next clock.
- R2: After opcode 0x9F, reply bytes 1, 2 and 3 (byte 0 is the opcode) are the manufacturer ID, the memory type and the device ID, with misoEn high for each.
- R3: After opcode 0xAB, bytes 1 to 3 are dummy bytes with misoEn low. Byte 4 carries the device ID with misoEn high.
- R4: After opcode 0x90, bytes 1 and 2 are dummy and byte 3 is a selector, all with misoEn low. A selector of 0x00 makes byte 4 the manufacturer ID and byte 5 the device ID.
- R5: For opcode 0x90 with any nonzero selector, byte 4 is the device ID and byte 5 is the manufacturer ID.
- R6: After opcode 0x05, every later byte of the transaction is the status byte: bit 7 is the write-disable parameter, bit 6 is 0, bits 5:2 are the block-protect parameter, bit 1 is the write-enable latch and bit 0 (busy) is 0.
- R7: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it, once the eighth bit of the opcode byte has been sampled. Power-on reset clears the latch.
- R8: Any other opcode keeps misoEn low for the rest of the transaction.
- R9: Reply bits leave MSB first. A new bit appears on each falling clock edge and is stable across the rising edge that follows.
- R10: After the last defined reply byte of an identification query (byte 4 onward for 0x9F, byte 5 onward for 0xAB, byte 6 onward for 0x90), misoEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| spiClk | input | 1 | Serial clock, mode 0 |
| csN | input | 1 | Chip select, active low; high resets the transaction |
| rstN | input | 1 | Power-on reset, active low; clears the write-enable latch |
| mosi | input | 1 | Serial data from host, sampled on rising edge |
| misoData | output | 1 | Serial reply data, 0 when not enabled |
| misoEn | output | 1 | Output enable for the reply pad |

## Verification
A wrong byte index or a wrong captured opcode shows up as a misplaced or missing misoEn window. It appears in the first reply byte after the fault, so within eight clocks. A bad selector capture swaps the two IDs in byte 4 of the 0x90 query. A latch that misses an update is invisible until the next status query, which reads bit 1 of its first reply byte. Because of that, every latch command is followed by a status read. The bench compares misoData and misoEn with a reference model before every rising edge. A single wrong bit is therefore caught in the bit where it occurs.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CNT_W = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] OP_JEDEC_ID   = 8'h9F;
  localparam logic [BYTE_W-1:0] OP_MFR_DEV_ID = 8'h90;
  localparam logic [BYTE_W-1:0] OP_WAKE_ID    = 8'hAB;
  localparam logic [BYTE_W-1:0] OP_READ_STAT  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_LATCH_SET  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_LATCH_CLR  = 8'h04;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_MFR,
    SRC_TYPE,
    SRC_DEV,
    SRC_STATUS
  } replySrc_e;

  typedef struct packed {
    logic      setWel;
    logic      clrWel;
    replySrc_e replySrc;
  } ctlStrobes_t;
endpackage

// File: rtl/spi_id_control.sv
module spi_id_control
  import spi_id_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              spiClk,
  input  logic              csN,
  input  logic              rstN,
  input  logic              byteEnd,
  input  logic [BYTE_W-1:0] rxByte,
  output ctlStrobes_t       strobes
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_SEL = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_ID_A = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_ID_B = IDX_W'(5);

  logic [IDX_W-1:0]  byteIdx;
  logic [BYTE_W-1:0] opcode;
  logic              selZero;

  always_ff @(posedge spiClk or posedge csN) begin
    if (csN) begin
      byteIdx <= '0;
      opcode  <= '0;
      selZero <= 1'b1;
    end else if (byteEnd) begin
      if (byteIdx != IDX_MAX) byteIdx <= byteIdx + 1'b1;
      if (byteIdx == '0) opcode <= rxByte;
      if (byteIdx == IDX_SEL) selZero <= (rxByte == '0);
    end
  end

  always_comb begin
    strobes.setWel   = byteEnd && (byteIdx == '0) && (rxByte == OP_LATCH_SET);
    strobes.clrWel   = byteEnd && (byteIdx == '0) && (rxByte == OP_LATCH_CLR);
    strobes.replySrc = SRC_NONE;
    if (byteIdx != '0) begin
      unique case (opcode)
        OP_JEDEC_ID: begin
          if (byteIdx == IDX_W'(1)) strobes.replySrc = SRC_MFR;
          else if (byteIdx == IDX_W'(2)) strobes.replySrc = SRC_TYPE;
          else if (byteIdx == IDX_W'(3)) strobes.replySrc = SRC_DEV;
        end
        OP_WAKE_ID: begin
          if (byteIdx == IDX_ID_A) strobes.replySrc = SRC_DEV;
        end
        OP_MFR_DEV_ID: begin
          if (byteIdx == IDX_ID_A) strobes.replySrc = selZero ? SRC_MFR : SRC_DEV;
          else if (byteIdx == IDX_ID_B) strobes.replySrc = selZero ? SRC_DEV : SRC_MFR;
        end
        OP_READ_STAT: strobes.replySrc = SRC_STATUS;
        default: strobes.replySrc = SRC_NONE;
      endcase
    end
  end

  // R7
  latch_cmds_exclusive_chk: assert property (@(posedge spiClk) disable iff (csN || !rstN)
    $onehot0({strobes.setWel, strobes.clrWel}));

  // R10
  jedec_tail_silent_chk: assert property (@(posedge spiClk) disable iff (csN || !rstN)
    (opcode == OP_JEDEC_ID && byteIdx > IDX_W'(3)) |-> (strobes.replySrc == SRC_NONE));
endmodule

// File: rtl/spi_id_datapath.sv
module spi_id_datapath
  import spi_id_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFR_ID      = 8'hC2,
  parameter logic [BYTE_W-1:0] MEM_TYPE    = 8'h20,
  parameter logic [BYTE_W-1:0] DEV_ID      = 8'h17,
  parameter logic [3:0]        PROTECT     = 4'b0101,
  parameter logic              WR_DISABLE  = 1'b1
) (
  input  logic              spiClk,
  input  logic              csN,
  input  logic              rstN,
  input  logic              mosi,
  input  ctlStrobes_t       strobes,
  output logic              byteEnd,
  output logic [BYTE_W-1:0] rxByte,
  output logic              misoData,
  output logic              misoEn
);
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [BYTE_W-2:0]    rxShift;
  logic [BYTE_W-1:0]    txShift;
  logic [BYTE_W-1:0]    replyByte;
  logic [BYTE_W-1:0]    statusByte;
  logic                 wel;

  always_ff @(posedge spiClk or posedge csN) begin
    if (csN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else begin
      bitCnt  <= bitCnt + 1'b1;
      rxShift <= {rxShift[BYTE_W-3:0], mosi};
    end
  end

  assign byteEnd = (bitCnt == BIT_CNT_W'(BYTE_W - 1));
  assign rxByte  = {rxShift, mosi};

  always_ff @(posedge spiClk or negedge rstN) begin
    if (!rstN) wel <= 1'b0;
    else if (!csN && strobes.setWel) wel <= 1'b1;
    else if (!csN && strobes.clrWel) wel <= 1'b0;
  end

  assign statusByte = {WR_DISABLE, 1'b0, PROTECT, wel, 1'b0};

  always_comb begin
    unique case (strobes.replySrc)
      SRC_MFR:    replyByte = MFR_ID;
      SRC_TYPE:   replyByte = MEM_TYPE;
      SRC_DEV:    replyByte = DEV_ID;
      SRC_STATUS: replyByte = statusByte;
      default:    replyByte = '0;
    endcase
  end

  always_ff @(negedge spiClk or posedge csN) begin
    if (csN) begin
      txShift <= '0;
      misoEn  <= 1'b0;
    end else if (bitCnt == '0) begin
      txShift <= replyByte;
      misoEn  <= (strobes.replySrc != SRC_NONE);
    end else begin
      txShift <= {txShift[BYTE_W-2:0], 1'b0};
    end
  end

  assign misoData = misoEn & txShift[BYTE_W-1];

  // R1
  idle_pad_off_chk: assert property (@(posedge spiClk) disable iff (!rstN)
    csN |-> !misoEn);

  // R7
  latch_set_chk: assert property (@(posedge spiClk) disable iff (!rstN || csN)
    strobes.setWel |=> wel);

  // R7
  latch_clr_chk: assert property (@(posedge spiClk) disable iff (!rstN || csN)
    strobes.clrWel |=> !wel);

  // R8
  silent_byte_chk: assert property (@(posedge spiClk) disable iff (!rstN || csN)
    (strobes.replySrc == SRC_NONE) |-> !misoEn);
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter logic [7:0] MFR_ID     = 8'hC2,
  parameter logic [7:0] MEM_TYPE   = 8'h20,
  parameter logic [7:0] DEV_ID     = 8'h17,
  parameter logic [3:0] PROTECT    = 4'b0101,
  parameter logic       WR_DISABLE = 1'b1
) (
  input  logic spiClk,
  input  logic csN,
  input  logic rstN,
  input  logic mosi,
  output logic misoData,
  output logic misoEn
);
  ctlStrobes_t       strobes;
  logic              byteEnd;
  logic [BYTE_W-1:0] rxByte;

  spi_id_control #(.IDX_W(3)) u_control (
    .spiClk (spiClk),
    .csN    (csN),
    .rstN   (rstN),
    .byteEnd(byteEnd),
    .rxByte (rxByte),
    .strobes(strobes)
  );

  spi_id_datapath #(
    .MFR_ID    (MFR_ID),
    .MEM_TYPE  (MEM_TYPE),
    .DEV_ID    (DEV_ID),
    .PROTECT   (PROTECT),
    .WR_DISABLE(WR_DISABLE)
  ) u_datapath (
    .spiClk  (spiClk),
    .csN     (csN),
    .rstN    (rstN),
    .mosi    (mosi),
    .strobes (strobes),
    .byteEnd (byteEnd),
    .rxByte  (rxByte),
    .misoData(misoData),
    .misoEn  (misoEn)
  );
endmodule

// File: tb/test_spi_id_responder.sv
module test_spi_id_responder;
  localparam int PERIOD = 20;
  localparam int HALF = PERIOD / 2;
  localparam logic [7:0] T_MFR = 8'hC2;
  localparam logic [7:0] T_TYPE = 8'h20;
  localparam logic [7:0] T_DEV = 8'h17;
  localparam logic [3:0] T_PROT = 4'b0101;
  localparam logic T_WD = 1'b1;

  logic spiClk = 1'b0, csN = 1'b1, rstN = 1'b0, mosi = 1'b0;
  logic misoData, misoEn;
  int checks = 0, errors = 0;
  logic [7:0] txBytes[$];
  logic [7:0] mOp;
  logic mSelZero;
  logic mWel = 1'b0;

  spi_id_responder #(.MFR_ID(T_MFR), .MEM_TYPE(T_TYPE), .DEV_ID(T_DEV),
    .PROTECT(T_PROT), .WR_DISABLE(T_WD)) i_spi_id_responder (
    .spiClk(spiClk), .csN(csN), .rstN(rstN), .mosi(mosi),
    .misoData(misoData), .misoEn(misoEn));

  function automatic logic [8:0] expectAt(int k);
    logic [7:0] st;
    st = {T_WD, 1'b0, T_PROT, mWel, 1'b0};
    if (k == 0) return 9'h000;
    case (mOp)
      8'h9F: if (k == 1) return {1'b1, T_MFR};
             else if (k == 2) return {1'b1, T_TYPE};
             else if (k == 3) return {1'b1, T_DEV};
      8'hAB: if (k == 4) return {1'b1, T_DEV};
      8'h90: if (k == 4) return {1'b1, mSelZero ? T_MFR : T_DEV};
             else if (k == 5) return {1'b1, mSelZero ? T_DEV : T_MFR};
      8'h05: return {1'b1, st};
      default: return 9'h000;
    endcase
    return 9'h000;
  endfunction

  task automatic check(input string tag, input logic expEn, input logic expD, input string where);
    checks++;
    if (misoEn !== expEn || misoData !== expD) begin
      errors++;
      $display("FAIL %s %s: misoEn=%b misoData=%b expected misoEn=%b misoData=%b",
               tag, where, misoEn, misoData, expEn, expD);
    end
  endtask

  // Drives txBytes as one transaction; compares every bit before its rising edge.
  task automatic runTxn(input string tag, input bit closeCs);
    logic [8:0] e;
    mOp = txBytes[0];
    mSelZero = 1'b1;
    csN = 1'b0;
    #HALF;
    for (int k = 0; k < txBytes.size(); k++) begin
      e = expectAt(k);
      for (int i = 0; i < 8; i++) begin
        mosi = txBytes[k][7-i];
        #(HALF/2);
        check(tag, e[8], e[8] ? e[7-i] : 1'b0, $sformatf("byte %0d bit %0d", k, i));
        #(HALF/2);
        spiClk = 1'b1;
        #HALF;
        spiClk = 1'b0;
      end
      if (k == 0 && mOp == 8'h06) mWel = 1'b1;
      if (k == 0 && mOp == 8'h04) mWel = 1'b0;
      if (k == 3) mSelZero = (txBytes[k] == 8'h00);
    end
    #(HALF/2);
    if (closeCs) begin
      csN = 1'b1;
      #(HALF/2);
      check("R1", 1'b0, 1'b0, "after csN rise");
      #HALF;
    end
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*2);
    check("R1", 1'b0, 1'b0, "during reset");
    rstN = 1'b1;
    #PERIOD;
    check("R1", 1'b0, 1'b0, "idle after reset");

    // R6 R7: status after reset, latch clear, repeated reads
    txBytes = '{8'h05, 8'h00, 8'h00, 8'h00};
    runTxn("R6", 1'b1);
    // R7: latch set
    txBytes = '{8'h06};
    runTxn("R7", 1'b1);
    txBytes = '{8'h05, 8'hFF, 8'h00};
    runTxn("R7", 1'b1);
    // R2 R10 R9: identification order and tail silence
    txBytes = '{8'h9F, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00};
    runTxn("R2", 1'b1);
    // R3 R10
    txBytes = '{8'hAB, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00};
    runTxn("R3", 1'b1);
    // R4: selector zero
    txBytes = '{8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    runTxn("R4", 1'b1);
    // R5: nonzero selectors swap order
    txBytes = '{8'h90, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00};
    runTxn("R5", 1'b1);
    txBytes = '{8'h90, 8'hAA, 8'h55, 8'hFF, 8'h00, 8'h00, 8'h00};
    runTxn("R5", 1'b1);
    // R8: unsupported opcodes stay silent
    txBytes = '{8'h3B, 8'h00, 8'hFF, 8'h00, 8'h00};
    runTxn("R8", 1'b1);
    txBytes = '{8'h00, 8'h9F, 8'h05};
    runTxn("R8", 1'b1);
    // R7: latch clear, then status shows it cleared
    txBytes = '{8'h04};
    runTxn("R7", 1'b1);
    txBytes = '{8'h05, 8'h00};
    runTxn("R7", 1'b1);
    // R1: abort mid-reply, then a fresh transaction starts from byte 0
    txBytes = '{8'h9F, 8'h00};
    runTxn("R1", 1'b1);
    txBytes = '{8'h9F, 8'h00, 8'h00, 8'h00};
    runTxn("R9", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule